// File: doc/BRIEF.md
# Counted Pulse Train Generator

This block drives one output with a burst of identical pulses. A configuration word, split into two equal halves, sets the length of one pulse period in clock ticks (lower half) and the number of ticks within each period during which the output is active (upper half). Writing a count to the count port launches a burst of exactly that many periods. The writer is never held off: a new count is taken on the cycle it is strobed. When the last period ends, a done flag rises and the output falls back to its idle level.

A polarity input turns the same timing into low-going pulses. An enable input plays the part of a pin drive-enable. While it is low, all burst state is held cleared and the output sits at its idle level. A configuration word written during that time is kept and is used by the first burst after the enable rises. An active-tick value of zero selects a level mode: the output is held active for the entire burst, which is count times period ticks long.

Top module: `pulse_train_gen`

## Requirements
- R1: Configuration bits [PER_W-1:0] set the period P in ticks and bits [2*PER_W-1:PER_W] set the active ticks A; every pulse of a burst spans exactly P ticks.
- R2: Within each period the output is active on phase ticks 0 to A-1 and inactive for the rest; when A is at least P the output is active for the whole period.
- R3: When A equals zero the output is continuously active for all N*P ticks of a burst of N pulses.
- R4: A count write of N launches a burst on the next cycle, starting at phase 0, with no ready or stall signal on the write.
- R5: The done flag reads 0 from the cycle after a nonzero count write until N*P ticks have passed, then reads 1 and stays 1 until the next count write; a count of zero sets done on the next cycle and produces no active ticks.
- R6: With invert at 1 every output level is flipped: active is 0 and idle is 1. With invert at 0, active is 1 and idle is 0.
- R7: While enable is low, the output is at its idle level, done reads 0 from the next cycle on, and count writes are ignored. Configuration writes made while enable is low are retained and are used after enable rises.
- R8: Period values of 0 and 1 behave exactly as a period of 2.
- R9: A count write during a running burst abandons that burst and restarts at phase 0 with the new count.
- R10: Once a burst ends, the output stays at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Drive enable; low holds burst state cleared |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 2*PER_W | Active ticks (upper half), period (lower half) |
| cnt_we | input | 1 | Count write strobe; starts a burst |
| cnt_data | input | CNT_W | Number of pulses in the burst |
| invert | input | 1 | Output polarity select |
| pulse_out | output | 1 | Pulse output |
| done | output | 1 | Burst-finished flag |

## Verification
The bench builds the block with a 4-bit period field and a 3-bit count. This makes every period from 0 to 15 and every active-tick value from 0 to 15 reachable, so the sweep covers the clamped periods, level mode, active ticks equal to or larger than the period, and zero, single and multi-pulse counts. Each tick of every burst is compared with a value computed arithmetically from phase = t mod P. Directed cases add a restart during a burst and enable-low sequences, with both polarities covered.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
   // Output stage variant: direct decode or one extra register stage.
   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_style_e;

   localparam int MIN_PERIOD = 2;
endpackage

// File: rtl/ptg_timebase.sv
module ptg_timebase #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             start,
   input  logic             run,
   input  logic [PER_W-1:0] period,
   output logic [PER_W-1:0] phase,
   output logic             wrap
);
   localparam logic [PER_W-1:0] MINP = PER_W'(ptg_pkg::MIN_PERIOD);

   logic [PER_W-1:0] eff_period;
   logic [PER_W-1:0] last_tick;

   // Periods under the minimum are stretched to it.
   assign eff_period = (period < MINP) ? MINP : period;
   assign last_tick  = eff_period - PER_W'(1);
   assign wrap       = run && (phase >= last_tick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          phase <= '0;
      else if (clr)        phase <= '0;
      else if (start)      phase <= '0;
      else if (wrap)       phase <= '0;
      else if (run)        phase <= phase + PER_W'(1);
   end
endmodule

// File: rtl/ptg_burst.sv
module ptg_burst #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             start,
   input  logic [CNT_W-1:0] load,
   input  logic             wrap,
   output logic             busy,
   output logic             done
);
   logic [CNT_W-1:0] remaining;

   assign busy = (remaining != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remaining <= '0;
         done      <= 1'b0;
      end else if (clr) begin
         remaining <= '0;
         done      <= 1'b0;
      end else if (start) begin
         remaining <= load;
         done      <= (load == '0);
      end else if (wrap && busy) begin
         remaining <= remaining - CNT_W'(1);
         if (remaining == CNT_W'(1)) done <= 1'b1;
      end
   end
endmodule

// File: rtl/ptg_outstage.sv
module ptg_outstage #(
   parameter int                    PER_W     = 16,
   parameter ptg_pkg::out_style_e   OUT_STYLE = ptg_pkg::OUT_COMB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             busy,
   input  logic [PER_W-1:0] phase,
   input  logic [PER_W-1:0] active_ticks,
   input  logic             invert,
   output logic             pulse_out
);
   logic level_mode;
   logic active;

   assign level_mode = (active_ticks == '0);
   assign active     = enable && busy && (level_mode || (phase < active_ticks));

   generate
      if (OUT_STYLE == ptg_pkg::OUT_REG) begin : g_reg
         logic act_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) act_q <= 1'b0;
            else        act_q <= active;
         end
         assign pulse_out = (act_q && enable) ^ invert;
      end else begin : g_comb
         assign pulse_out = active ^ invert;
      end
   endgenerate
endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen #(
   parameter int                  PER_W     = 16,
   parameter int                  CNT_W     = 16,
   parameter ptg_pkg::out_style_e OUT_STYLE = ptg_pkg::OUT_COMB
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic                 cfg_we,
   input  logic [2*PER_W-1:0]   cfg_data,
   input  logic                 cnt_we,
   input  logic [CNT_W-1:0]     cnt_data,
   input  logic                 invert,
   output logic                 pulse_out,
   output logic                 done
);
   localparam int CFG_W = 2 * PER_W;

   generate
      if (PER_W < 2)  begin : g_bad_per  $error("PER_W must be at least 2"); end
      if (CNT_W < 1)  begin : g_bad_cnt  $error("CNT_W must be at least 1"); end
   endgenerate

   logic [CFG_W-1:0] cfg_q;
   logic             clr;
   logic             start;
   logic             run;
   logic             wrap;
   logic [PER_W-1:0] phase;

   // Configuration is retained regardless of enable.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_we) cfg_q <= cfg_data;
   end

   assign clr   = !enable;
   assign start = enable && cnt_we;

   ptg_timebase #(.PER_W(PER_W)) u_tb (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .start  (start),
      .run    (run),
      .period (cfg_q[PER_W-1:0]),
      .phase  (phase),
      .wrap   (wrap)
   );

   ptg_burst #(.CNT_W(CNT_W)) u_burst (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .start (start),
      .load  (cnt_data),
      .wrap  (wrap),
      .busy  (run),
      .done  (done)
   );

   ptg_outstage #(.PER_W(PER_W), .OUT_STYLE(OUT_STYLE)) u_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .busy         (run),
      .phase        (phase),
      .active_ticks (cfg_q[CFG_W-1:PER_W]),
      .invert       (invert),
      .pulse_out    (pulse_out)
   );
endmodule

// File: rtl/pulse_train_chk.sv
module pulse_train_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             cnt_we,
   input logic [CNT_W-1:0] cnt_data,
   input logic             invert,
   input logic             pulse_out,
   input logic             done
);
   assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (pulse_out == invert));

   assert_done_clears_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !done);

   assert_start_clears_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && cnt_we && (cnt_data != '0)) |=> !done);

   assert_zero_count_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && cnt_we && (cnt_data == '0)) |=> done);

   assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !cnt_we && done) |=> done || !enable);

   assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pulse_out == invert));
endmodule

bind pulse_train_gen pulse_train_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable    (enable),
   .cnt_we    (cnt_we),
   .cnt_data  (cnt_data),
   .invert    (invert),
   .pulse_out (pulse_out),
   .done      (done)
);

// File: tb/tb_pulse_train_gen.sv
module tb_pulse_train_gen;
   localparam int PER_W = 4;
   localparam int CNT_W = 3;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               enable = 1'b0;
   logic               cfg_we = 1'b0;
   logic [2*PER_W-1:0] cfg_data = '0;
   logic               cnt_we = 1'b0;
   logic [CNT_W-1:0]   cnt_data = '0;
   logic               invert = 1'b0;
   logic               pulse_out;
   logic               done;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   pulse_train_gen #(.PER_W(PER_W), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
      .cfg_data(cfg_data), .cnt_we(cnt_we), .cnt_data(cnt_data),
      .invert(invert), .pulse_out(pulse_out), .done(done)
   );

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
      end
   endtask

   task automatic write_cfg(input int p, input int a);
      @(negedge clk);
      cfg_data = {4'(a), 4'(p)};
      cfg_we   = 1'b1;
      @(negedge clk);
      cfg_we   = 1'b0;
   endtask

   // Strobe a count; returns at the first sample after the capturing edge (t=0).
   task automatic write_cnt(input int n);
      cnt_data = 3'(n);
      cnt_we   = 1'b1;
      @(negedge clk);
      cnt_we   = 1'b0;
   endtask

   // Compare ticks [t0, t1) of a burst with the arithmetic model.
   task automatic follow(input int p, input int a, input int n, input bit inv,
                         input int t0, input int t1, input string req);
      int ep;
      ep = (p < 2) ? 2 : p;
      for (int t = t0; t < t1; t++) begin
         logic act_e;
         logic done_e;
         if (t < ep * n) begin
            act_e  = (a == 0) || ((t % ep) < a);
            done_e = 1'b0;
         end else begin
            act_e  = 1'b0;
            done_e = 1'b1;
         end
         check(req, pulse_out, act_e ^ inv);
         check("R5", done, done_e);
         if (t + 1 < t1) @(negedge clk);
      end
   endtask

   task automatic burst(input int p, input int a, input int n, input bit inv);
      string req;
      int ep;
      ep = (p < 2) ? 2 : p;
      if (p < 2)       req = "R8";
      else if (a == 0) req = "R3";
      else if (a >= p) req = "R2";
      else             req = "R1";
      invert = inv;
      write_cfg(p, a);
      write_cnt(n);
      follow(p, a, n, inv, 0, ep * n + 2, req);
      check("R10", pulse_out, inv);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // Reset state
      check("R7", pulse_out, 1'b0);
      check("R5", done, 1'b0);
      rst_n = 1'b1;

      // R7: enable low - count ignored, config retained
      invert = 1'b1;
      write_cfg(3, 1);
      write_cnt(2);
      for (int i = 0; i < 6; i++) begin
         check("R7", pulse_out, 1'b1);
         check("R7", done, 1'b0);
         @(negedge clk);
      end
      enable = 1'b1;
      @(negedge clk);
      check("R7", done, 1'b0);
      write_cnt(2);
      follow(3, 1, 2, 1'b1, 0, 8, "R7");

      // R4: burst start, and R7: enable dropped mid-burst
      invert = 1'b0;
      write_cfg(4, 2);
      write_cnt(3);
      follow(4, 2, 3, 1'b0, 0, 3, "R4");
      enable = 1'b0;
      #1;
      check("R7", pulse_out, 1'b0);
      @(negedge clk);
      check("R7", done, 1'b0);
      check("R7", pulse_out, 1'b0);
      enable = 1'b1;
      @(negedge clk);

      // R9: restart during a burst
      write_cnt(3);
      follow(4, 2, 3, 1'b0, 0, 6, "R4");
      write_cnt(2);
      follow(4, 2, 2, 1'b0, 0, 10, "R9");

      // Sweep of period, active ticks and count
      for (int p = 0; p < 16; p++) begin
         for (int a = 0; a < 16; a++) begin
            for (int ni = 0; ni < 3; ni++) begin
               burst(p, a, (ni == 2) ? 3 : ni, 1'((p + a + ni) % 2));
            end
         end
      end

      // R6: explicit polarity pair on one pattern
      burst(5, 2, 2, 1'b0);
      burst(5, 2, 2, 1'b1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule